// File: doc/BRIEF.md
# Multiplexed-Bus Address Decoder

This block sits beside an 8-bit controller whose bus runs in expanded mode. On that bus the low address byte and the data share one set of lines, and the high address byte has lines of its own. The block takes the low byte off the shared lines while the active-high address strobe is asserted and holds it. It joins that byte with the live high byte to form a 16-bit address. It then decodes the address into one-hot selects for eight 4 KB program blocks, one 2 KB data-RAM region and one I/O register window.

Each region has its own base address on static configuration inputs, so each region can be placed anywhere on its own boundary. The I/O window's size, and with it its alignment, can be set to 256 B, 512 B, 1 KB or 2 KB. When regions overlap, a fixed priority picks one winner. The selects and the read and write enables are active only during the E-high data phase, with R/W choosing the direction.

Top module: `mux_addr_decoder`

## Requirements
- R1: At every rising clock edge where `as_i` is high, the byte on `ad_i` is captured, and `addr_o[7:0]` shows it after that edge.
- R2: At edges where `as_i` is low, the captured low byte keeps its value, whatever `ad_i` carries. It therefore stays stable through the E-high data phase.
- R3: `addr_o[15:8]` follows `a_hi_i` directly, with no clock delay.
- R4: Program block k (k = 0..7) matches when `addr_o[15:12]` equals `prog_base_i[4k+3:4k]`. If several blocks match, the lowest k wins.
- R5: The data-RAM region matches when `addr_o[15:11]` equals `ram_base_i`.
- R6: The I/O window size is 256 B shifted left by `io_size_i` (0 gives 256 B, 3 gives 2 KB). The window matches when `addr_o[15:8]` and `io_base_i` agree in bits [7:io_size_i] of the byte. Base bits below that are ignored.
- R7: Priority is the I/O window, then data RAM, then program blocks. At most one of `io_cs_o`, `ram_cs_o`, `prog_cs_o` is high at a time. All of them are low when nothing matches.
- R8: Selects and enables are driven only while `e_i` is high. `rd_en_o` is high when `rw_i` is high, and `wr_en_o` is high when `rw_i` is low.
- R9: While `rst_n` is low, all selects and enables are low and the captured low byte is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side sampling clock |
| rst_n | input | 1 | Active-low reset |
| as_i | input | 1 | Address strobe, active high |
| ad_i | input | 8 | Shared low-address/data lines |
| a_hi_i | input | 8 | Dedicated high address lines |
| e_i | input | 1 | E clock (data phase when high) |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| prog_base_i | input | 32 | Four-bit base tag per program block, block k in bits [4k+3:4k] |
| ram_base_i | input | 5 | Data-RAM base tag (address bits 15..11) |
| io_base_i | input | 8 | I/O window base tag (address bits 15..8) |
| io_size_i | input | 2 | I/O window size code |
| addr_o | output | 16 | Assembled address |
| prog_cs_o | output | 8 | Program block selects, one-hot |
| ram_cs_o | output | 1 | Data-RAM select |
| io_cs_o | output | 1 | I/O window select |
| rd_en_o | output | 1 | Read enable |
| wr_en_o | output | 1 | Write enable |

## Verification
The low byte becomes visible one rising edge after the strobe is sampled high. The selects, the enables and the high byte respond to their inputs within the same cycle. The driver asserts the strobe at a falling edge and lets one rising edge capture the byte. It then drops the strobe, puts junk on the shared lines and raises E at the next falling edge. The monitor samples 1 ns after the following rising edge. So each comparison lands after exactly one capture edge and one hold edge, and covers the hold requirement as well as the decode.

// File: rtl/mux_addr_decoder_pkg.sv
package mux_addr_decoder_pkg;
  localparam int ADDR_W      = 16;
  localparam int BYTE_W      = 8;
  localparam int PROG_LOG2   = 12;
  localparam int RAM_LOG2    = 11;
  localparam int IO_LOG2     = 8;
  localparam int IO_SZ_W     = 2;
  localparam int HI_W        = ADDR_W - BYTE_W;
  localparam int PROG_TAG_W  = ADDR_W - PROG_LOG2;
  localparam int RAM_TAG_W   = ADDR_W - RAM_LOG2;
  localparam int IO_TAG_W    = ADDR_W - IO_LOG2;

  // tag equality for a fixed-size region
  function automatic logic prog_match(input logic [PROG_TAG_W-1:0] a_tag,
                                      input logic [PROG_TAG_W-1:0] base);
    return a_tag == base;
  endfunction

  function automatic logic ram_match(input logic [RAM_TAG_W-1:0] a_tag,
                                     input logic [RAM_TAG_W-1:0] base);
    return a_tag == base;
  endfunction

  // window whose low tag bits are don't-care according to the size code
  function automatic logic [IO_TAG_W-1:0] io_mask(input logic [IO_SZ_W-1:0] sz);
    return {IO_TAG_W{1'b1}} << sz;
  endfunction

  function automatic logic io_match(input logic [IO_TAG_W-1:0] a_tag,
                                    input logic [IO_TAG_W-1:0] base,
                                    input logic [IO_SZ_W-1:0]  sz);
    return ((a_tag ^ base) & io_mask(sz)) == '0;
  endfunction
endpackage

// File: rtl/mux_addr_decoder_lo_latch.sv
module mux_addr_decoder_lo_latch
  import mux_addr_decoder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] bus_byte,
  output logic [BYTE_W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (strobe) lo_q <= bus_byte;
  end
endmodule

// File: rtl/mux_addr_decoder_match.sv
module mux_addr_decoder_match
  import mux_addr_decoder_pkg::*;
#(
  parameter int N_PROG = 8
) (
  input  logic [HI_W-1:0]              hi_byte,
  input  logic [N_PROG*PROG_TAG_W-1:0] prog_base,
  input  logic [RAM_TAG_W-1:0]         ram_base,
  input  logic [IO_TAG_W-1:0]          io_base,
  input  logic [IO_SZ_W-1:0]           io_size,
  output logic [N_PROG-1:0]            prog_hit,
  output logic                         ram_hit,
  output logic                         io_hit
);
  for (genvar k = 0; k < N_PROG; k++) begin : g_prog
    assign prog_hit[k] = prog_match(hi_byte[HI_W-1 -: PROG_TAG_W],
                                    prog_base[k*PROG_TAG_W +: PROG_TAG_W]);
  end

  assign ram_hit = ram_match(hi_byte[HI_W-1 -: RAM_TAG_W], ram_base);
  assign io_hit  = io_match(hi_byte[HI_W-1 -: IO_TAG_W], io_base, io_size);
endmodule

// File: rtl/mux_addr_decoder_arb.sv
module mux_addr_decoder_arb #(
  parameter int N_PROG = 8
) (
  input  logic              rst_n,
  input  logic              e_clk,
  input  logic              rw,
  input  logic [N_PROG-1:0] prog_hit,
  input  logic              ram_hit,
  input  logic              io_hit,
  output logic [N_PROG-1:0] prog_cs,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              rd_en,
  output logic              wr_en
);
  logic              phase_ok;
  logic [N_PROG-1:0] prog_win;
  logic              taken;

  assign phase_ok = rst_n & e_clk;

  // lowest-index program block wins among overlapping ones
  always_comb begin
    prog_win = '0;
    taken    = 1'b0;
    for (int k = 0; k < N_PROG; k++) begin
      if (prog_hit[k] && !taken) begin
        prog_win[k] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  assign io_cs   = phase_ok & io_hit;
  assign ram_cs  = phase_ok & ram_hit & ~io_hit;
  assign prog_cs = (phase_ok & ~io_hit & ~ram_hit) ? prog_win : '0;
  assign rd_en   = phase_ok & rw;
  assign wr_en   = phase_ok & ~rw;
endmodule

// File: rtl/mux_addr_decoder.sv
module mux_addr_decoder
  import mux_addr_decoder_pkg::*;
#(
  parameter int N_PROG = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         as_i,
  input  logic [BYTE_W-1:0]            ad_i,
  input  logic [HI_W-1:0]              a_hi_i,
  input  logic                         e_i,
  input  logic                         rw_i,
  input  logic [N_PROG*PROG_TAG_W-1:0] prog_base_i,
  input  logic [RAM_TAG_W-1:0]         ram_base_i,
  input  logic [IO_TAG_W-1:0]          io_base_i,
  input  logic [IO_SZ_W-1:0]           io_size_i,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [N_PROG-1:0]            prog_cs_o,
  output logic                         ram_cs_o,
  output logic                         io_cs_o,
  output logic                         rd_en_o,
  output logic                         wr_en_o
);
  logic [BYTE_W-1:0] lo_byte_w;
  logic [N_PROG-1:0] prog_hit_w;
  logic              ram_hit_w;
  logic              io_hit_w;

  mux_addr_decoder_lo_latch u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (as_i),
    .bus_byte (ad_i),
    .lo_q     (lo_byte_w)
  );

  assign addr_o = {a_hi_i, lo_byte_w};

  mux_addr_decoder_match #(.N_PROG(N_PROG)) u_match (
    .hi_byte   (a_hi_i),
    .prog_base (prog_base_i),
    .ram_base  (ram_base_i),
    .io_base   (io_base_i),
    .io_size   (io_size_i),
    .prog_hit  (prog_hit_w),
    .ram_hit   (ram_hit_w),
    .io_hit    (io_hit_w)
  );

  mux_addr_decoder_arb #(.N_PROG(N_PROG)) u_arb (
    .rst_n    (rst_n),
    .e_clk    (e_i),
    .rw       (rw_i),
    .prog_hit (prog_hit_w),
    .ram_hit  (ram_hit_w),
    .io_hit   (io_hit_w),
    .prog_cs  (prog_cs_o),
    .ram_cs   (ram_cs_o),
    .io_cs    (io_cs_o),
    .rd_en    (rd_en_o),
    .wr_en    (wr_en_o)
  );
endmodule

// File: rtl/mux_addr_decoder_chk.sv
module mux_addr_decoder_chk #(
  parameter int N_PROG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_i,
  input logic [7:0]        ad_i,
  input logic              e_i,
  input logic              rw_i,
  input logic [15:0]       addr_o,
  input logic [N_PROG-1:0] prog_cs_o,
  input logic              ram_cs_o,
  input logic              io_cs_o,
  input logic              rd_en_o,
  input logic              wr_en_o,
  input logic [N_PROG-1:0] prog_hit_w,
  input logic              ram_hit_w,
  input logic              io_hit_w
);
  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    as_i |=> addr_o[7:0] == $past(ad_i)); // R1
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !as_i |=> $stable(addr_o[7:0])); // R2
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_cs_o, ram_cs_o, prog_cs_o})); // R7
  AST_IO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit_w && e_i) |-> io_cs_o); // R7
  AST_RAM_OVER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit_w && !io_hit_w && e_i) |-> (ram_cs_o && prog_cs_o == '0)); // R7
  AST_PROG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_cs_o & ~prog_hit_w) == '0); // R4
  AST_CS_NEEDS_E: assert property (@(posedge clk) disable iff (!rst_n)
    !e_i |-> !(io_cs_o || ram_cs_o || (|prog_cs_o) || rd_en_o || wr_en_o)); // R8
  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    e_i |-> (rd_en_o == rw_i && wr_en_o == !rw_i)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(io_cs_o || ram_cs_o || (|prog_cs_o) || rd_en_o || wr_en_o)); // R9
endmodule

bind mux_addr_decoder mux_addr_decoder_chk #(.N_PROG(N_PROG)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .as_i       (as_i),
  .ad_i       (ad_i),
  .e_i        (e_i),
  .rw_i       (rw_i),
  .addr_o     (addr_o),
  .prog_cs_o  (prog_cs_o),
  .ram_cs_o   (ram_cs_o),
  .io_cs_o    (io_cs_o),
  .rd_en_o    (rd_en_o),
  .wr_en_o    (wr_en_o),
  .prog_hit_w (prog_hit_w),
  .ram_hit_w  (ram_hit_w),
  .io_hit_w   (io_hit_w)
);

// File: tb/mux_addr_decoder_tb_top.sv
module mux_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_i = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic [7:0]  a_hi_i = 8'h00;
  logic        e_i = 1'b0;
  logic        rw_i = 1'b1;
  logic [31:0] prog_base_i = 32'h0;
  logic [4:0]  ram_base_i = 5'h0;
  logic [7:0]  io_base_i = 8'h0;
  logic [1:0]  io_size_i = 2'd0;
  logic [15:0] addr_o;
  logic [7:0]  prog_cs_o;
  logic        ram_cs_o, io_cs_o, rd_en_o, wr_en_o;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [9:0]  cs;
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event smp_ev;

  always #2.5 clk = ~clk;

  mux_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ad_i(ad_i), .a_hi_i(a_hi_i),
    .e_i(e_i), .rw_i(rw_i), .prog_base_i(prog_base_i), .ram_base_i(ram_base_i),
    .io_base_i(io_base_i), .io_size_i(io_size_i), .addr_o(addr_o),
    .prog_cs_o(prog_cs_o), .ram_cs_o(ram_cs_o), .io_cs_o(io_cs_o),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o)
  );

  // bit 9 = I/O, bit 8 = RAM, bits 7:0 = program blocks
  function automatic logic [9:0] model_cs(input logic [15:0] a, input logic e);
    int unsigned ai;
    logic [9:0] r;
    ai = a;
    r  = '0;
    if (!e) return r;
    if ((ai >> (8 + int'(io_size_i))) == (int'(io_base_i) >> int'(io_size_i)))
      return 10'h200;
    if (ai / 2048 == int'(ram_base_i)) return 10'h100;
    for (int k = 7; k >= 0; k--)
      if (ai / 4096 == int'(prog_base_i[4*k +: 4])) r = 10'(1 << k);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // driver: predicts, then runs one strobe + data phase
  task automatic access(input logic [15:0] a, input logic rw, input logic e, input string tag);
    exp_t it;
    it.cs   = model_cs(a, e);
    it.rd   = e & rw;
    it.wr   = e & ~rw;
    it.addr = a;
    it.tag  = tag;
    sb_q.push_back(it);
    @(negedge clk);
    as_i = 1'b1; ad_i = a[7:0]; a_hi_i = a[15:8]; e_i = 1'b0;
    @(negedge clk);
    as_i = 1'b0; ad_i = ~a[7:0]; e_i = e; rw_i = rw;
    @(posedge clk);
    #1 -> smp_ev;
    @(negedge clk);
    e_i = 1'b0; ad_i = 8'h00;
  endtask

  // monitor
  initial begin
    exp_t it;
    forever begin
      @(smp_ev);
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard empty", "sample", "item");
      end else begin
        it = sb_q.pop_front();
        check({io_cs_o, ram_cs_o, prog_cs_o} == it.cs, it.tag,
              $sformatf("cs=%h", {io_cs_o, ram_cs_o, prog_cs_o}), $sformatf("cs=%h", it.cs));
        check(rd_en_o == it.rd && wr_en_o == it.wr, {it.tag, " R8 dir"},
              $sformatf("rd=%0b wr=%0b", rd_en_o, wr_en_o), $sformatf("rd=%0b wr=%0b", it.rd, it.wr));
        check(addr_o == it.addr, {it.tag, " R1 R2 R3 addr"},
              $sformatf("%h", addr_o), $sformatf("%h", it.addr));
      end
    end
  end

  initial begin
    #200us;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // blocks k at 0x8000 + k*0x1000, RAM at 0x2000, I/O at 0x3000 (256 B)
    for (int k = 0; k < 8; k++) prog_base_i[4*k +: 4] = 4'(8 + k);
    ram_base_i = 5'b00100;
    io_base_i  = 8'h30;
    io_size_i  = 2'd0;
    // R9: strobe, E and a matching address all active during reset
    as_i = 1'b1; ad_i = 8'h5A; a_hi_i = 8'h80; e_i = 1'b1; rw_i = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check({io_cs_o, ram_cs_o, prog_cs_o, rd_en_o, wr_en_o} == '0, "R9 reset selects",
          $sformatf("%h", {io_cs_o, ram_cs_o, prog_cs_o, rd_en_o, wr_en_o}), "0");
    check(addr_o[7:0] == 8'h00, "R9 reset low byte", $sformatf("%h", addr_o[7:0]), "00");
    @(negedge clk);
    as_i = 1'b0; e_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    access(16'h8123, 1'b1, 1'b1, "R4 block0 read");
    access(16'hF0AA, 1'b0, 1'b1, "R4 block7 write");
    access(16'hA7FE, 1'b1, 1'b1, "R4 block2");
    access(16'h2345, 1'b0, 1'b1, "R5 RAM");
    access(16'h27FF, 1'b1, 1'b1, "R5 RAM top");
    access(16'h2800, 1'b1, 1'b1, "R5 RAM miss");
    access(16'h3010, 1'b1, 1'b1, "R6 IO 256B hit");
    access(16'h3110, 1'b1, 1'b1, "R6 IO 256B miss");
    access(16'h8123, 1'b1, 1'b0, "R8 E low no select");
    io_size_i = 2'd3;
    access(16'h3710, 1'b0, 1'b1, "R6 IO 2K hit");
    access(16'h3800, 1'b0, 1'b1, "R6 IO 2K miss");
    io_base_i = 8'h41; io_size_i = 2'd1;
    access(16'h41FF, 1'b1, 1'b1, "R6 IO 512B base low bit ignored");
    access(16'h4200, 1'b1, 1'b1, "R6 IO 512B miss");
    io_base_i = 8'h20; io_size_i = 2'd3;
    access(16'h2100, 1'b1, 1'b1, "R7 IO over RAM");
    io_base_i = 8'hE0; io_size_i = 2'd0;
    prog_base_i[11:8] = 4'h2;
    access(16'h2100, 1'b1, 1'b1, "R7 RAM over block2");
    access(16'h2900, 1'b0, 1'b1, "R7 block2 alone");
    access(16'hE000, 1'b1, 1'b1, "R7 IO over block6");
    prog_base_i[23:20] = 4'h8;
    access(16'h8000, 1'b1, 1'b1, "R4 lowest block wins");
    access(16'h1234, 1'b1, 1'b1, "R7 no match");

    // R3: high byte passes with no clock delay
    @(negedge clk);
    a_hi_i = 8'h5C;
    #1;
    check(addr_o[15:8] == 8'h5C, "R3 high byte direct", $sformatf("%h", addr_o[15:8]), "5c");
    // R2: low byte held over many edges with strobe low
    ad_i = 8'hC3;
    repeat (5) @(posedge clk);
    #1;
    check(addr_o[7:0] == 8'h34, "R2 hold over idle edges", $sformatf("%h", addr_o[7:0]), "34");

    repeat (3) @(posedge clk);
    check(sb_q.size() == 0, "scoreboard drained", $sformatf("%0d", sb_q.size()), "0");
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule